// File: doc/BRIEF.md
# Prescaled Event Timer with Two Compare Channels

This block is an 8-bit timer/counter that sits behind a small register port. A 3-bit source select picks the count source. The counter can be stopped. It can advance from the system clock divided by one of five fixed ratios. It can also count edges on an external event pin, which is synchronized inside the block. Software can load and read the counter at any time. When the counter wraps from 255 to 0, it raises an overflow flag.

Two compare channels each hold a compare value. On every advance, each channel tests whether the new counter value equals its compare value. On a match the channel sets its own flag, and it can toggle its own output pin. A force bit toggles a channel's pin at once, without a match. Each flag has an enable bit in a mask register. The interrupt request is high while any enabled flag is set. Flags are cleared by writing ones to them.

The register port is a plain synchronous strobe: a write completes on the clock edge where `wr_en` is high, and `rdata` shows the register selected by `addr` in the same cycle. Every access is accepted at once, so the port has no back-pressure and no handshake.

Top module: `evt_timer`

## Requirements
- R1: After reset, these all read 0: the control, counter, both compare, mask and flag registers. The `irq` and `cmp_out` outputs are also 0.
- R2: Source select is control bits [2:0]. Value 0 holds the counter. Values 1, 2, 3, 4 and 5 advance it by one on every 1st, 8th, 64th, 256th and 1024th clock edge, counted from reset release. The divider runs freely and is never cleared by register writes.
- R3: A write to address 1 loads the counter on that edge. The load takes priority over an advance in the same cycle, and no overflow or match is raised on that edge.
- R4: An advance from 255 gives 0 and sets flag bit 0 (overflow).
- R5: On an advance where the new counter value equals compare A (address 2), flag bit 1 is set. When it equals compare B (address 3), flag bit 2 is set.
- R6: Writing to the flag register (address 5) clears each bit written as 1. Bits written as 0 are left as they are. A flag set by an event in the same cycle as its clear stays set.
- R7: `irq` is 1 exactly when a flag bit and the mask bit in the same position (address 4, bits [2:0]) are both 1.
- R8: Control bit 3 (channel A) and control bit 4 (channel B) make that channel's `cmp_out` bit (bit 0 = A, bit 1 = B) toggle on each of its matches. When the bit is 0, matches leave the pin alone.
- R9: Writing control bit 5 (A) or bit 6 (B) as 1 toggles that pin on the same edge, whatever the mode bit is. It sets no flag, and the force bits read back as 0. A force and a match in one cycle give a single toggle.
- R10: Source values 7 and 6 count rising and falling edges of `ext_evt`, respectively. The pin passes two synchronizing flops, so an edge is counted within four clock edges. Edges of the other polarity are not counted. Each pin level must be held for at least two clocks.
- R11: Read map: 0 = control bits [4:0], 1 = counter, 2 = compare A, 3 = compare B, 4 = mask, 5 = flags. Unused upper bits read 0. Addresses 6 and 7 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 3 | Register index for both read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the register at `addr` |
| ext_evt | input | 1 | External event pin, asynchronous |
| irq | output | 1 | Interrupt request |
| cmp_out | output | 2 | Compare outputs, bit 0 channel A, bit 1 channel B |

## Verification
A divider phase that drifts, or a tap that is chosen wrongly, shows up within one prescale period as a counter read one off. It also moves the overflow and match flags by whole periods, which the port checks see on the next sampled cycle. A flag, mask or output-toggle state that goes wrong appears at `irq` or `cmp_out` on the edge right after the event that set it. The bench compares those pins on every cycle against a model that advances on the stated edge numbers. External counting is checked after a settle window, including a check that opposite-polarity edges leave the counter unchanged.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int ADDR_W = 3;
  localparam int NUM_CH = 2;
  localparam int NUM_FLG = NUM_CH + 1;
  localparam int CTRL_W = 5;
  localparam int MODE_LSB = 3;
  localparam int FORCE_LSB = 5;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP0  = 3'd2;
  localparam logic [ADDR_W-1:0] A_MASK  = 3'd4;
  localparam logic [ADDR_W-1:0] A_FLAGS = 3'd5;

  // number of low divider bits that must all be one for a prescaled tick
  function automatic int tap_bits(input logic [2:0] sel);
    case (sel)
      3'd2:    return 3;
      3'd3:    return 6;
      3'd4:    return 8;
      3'd5:    return 10;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale #(
  parameter int DIV_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       ext_pin,
  output logic       tick
);
  import tmr_pkg::*;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] tap_mask;
  logic             sync1_q, sync2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      div_q   <= div_q + DIV_W'(1);
      sync1_q <= ext_pin;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_comb begin
    for (int i = 0; i < DIV_W; i++) tap_mask[i] = (i < tap_bits(sel));
  end

  always_comb begin
    case (sel)
      3'd0:    tick = 1'b0;
      3'd6:    tick = prev_q & ~sync2_q;
      3'd7:    tick = sync2_q & ~prev_q;
      default: tick = ((div_q & tap_mask) == tap_mask);
    endcase
  end
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmp_we,
  input  logic [W-1:0] wdata,
  input  logic         adv,
  input  logic [W-1:0] cnt_next,
  input  logic         mode,
  input  logic         force_tgl,
  output logic [W-1:0] cmp_q,
  output logic         match,
  output logic         pin
);
  assign match = adv && (cnt_next == cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
      pin   <= 1'b0;
    end else begin
      if (cmp_we) cmp_q <= wdata;
      pin <= pin ^ (force_tgl | (match & mode));
    end
  end
endmodule

// File: rtl/evt_timer.sv
`timescale 1ns/1ps
module evt_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ext_evt,
  output logic              irq,
  output logic [NUM_CH-1:0] cmp_out
);
  logic [CTRL_W-1:0]  ctrl_q;
  logic [DATA_W-1:0]  count_q, cnt_next;
  logic [NUM_FLG-1:0] mask_q, flags_q, flag_set, flag_clr;
  logic [DATA_W-1:0]  cmp_val [NUM_CH];
  logic [NUM_CH-1:0]  ch_match;
  logic               tick, load, adv, wrap;

  tmr_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .sel(ctrl_q[2:0]), .ext_pin(ext_evt), .tick(tick)
  );

  assign load     = wr_en && (addr == A_COUNT);
  assign adv      = tick && !load;
  assign cnt_next = count_q + DATA_W'(1);
  assign wrap     = adv && (&count_q);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] CH_ADDR = A_CMP0 + ADDR_W'(c);
    tmr_channel #(.W(DATA_W)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .cmp_we(wr_en && (addr == CH_ADDR)),
      .wdata(wdata), .adv(adv), .cnt_next(cnt_next),
      .mode(ctrl_q[MODE_LSB + c]),
      .force_tgl(wr_en && (addr == A_CTRL) && wdata[FORCE_LSB + c]),
      .cmp_q(cmp_val[c]), .match(ch_match[c]), .pin(cmp_out[c])
    );
  end

  assign flag_set = {ch_match, wrap};
  assign flag_clr = (wr_en && (addr == A_FLAGS)) ? wdata[NUM_FLG-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      count_q <= '0;
      mask_q  <= '0;
      flags_q <= '0;
    end else begin
      if (wr_en && (addr == A_CTRL)) ctrl_q <= wdata[CTRL_W-1:0];
      if (wr_en && (addr == A_MASK)) mask_q <= wdata[NUM_FLG-1:0];
      if (load)     count_q <= wdata;
      else if (adv) count_q <= cnt_next;
      flags_q <= (flags_q & ~flag_clr) | flag_set;
    end
  end

  assign irq = |(flags_q & mask_q);

  always_comb begin
    case (addr)
      A_CTRL:  rdata = DATA_W'(ctrl_q);
      A_COUNT: rdata = count_q;
      3'd2:    rdata = cmp_val[0];
      3'd3:    rdata = cmp_val[1];
      A_MASK:  rdata = DATA_W'(mask_q);
      A_FLAGS: rdata = DATA_W'(flags_q);
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/evt_timer_chk.sv
`timescale 1ns/1ps
module evt_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [2:0]   addr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] count_q,
  input logic [2:0]   flags_q,
  input logic [W-1:0] cmp_a,
  input logic [2:0]   sel,
  input logic         tick
);
  logic ld;
  assign ld = wr_en && (addr == 3'd1);

  assert_count_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> count_q == $past(wdata));

  assert_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd0 && !ld) |=> $stable(count_q));

  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> (count_q == $past(count_q)) || (count_q == $past(count_q) + W'(1)));

  assert_tick_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel >= 3'd2 && sel <= 3'd5 && !(wr_en && addr == 3'd0)) |=> !tick);

  assert_ovf_after_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q[0]) |-> (&$past(count_q)) && count_q == '0);

  assert_match_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q[1]) |-> count_q == $past(cmp_a));
endmodule

bind evt_timer evt_timer_chk #(.W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .count_q(count_q), .flags_q(flags_q), .cmp_a(cmp_val[0]),
  .sel(ctrl_q[2:0]), .tick(tick)
);

// File: tb/evt_timer_test.sv
`timescale 1ns/1ps
module evt_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd1;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       ext_evt = 1'b0;
  logic       irq;
  logic [1:0] cmp_out;

  evt_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ext_evt(ext_evt), .irq(irq), .cmp_out(cmp_out)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  bit ext_skip = 1'b0;

  logic [4:0] m_ctrl;
  logic [7:0] m_cnt, m_cmp0, m_cmp1;
  logic [2:0] m_mask, m_flags;
  logic [1:0] m_out;
  int         e;

  function automatic int ratio(input logic [2:0] s);
    case (s)
      3'd1: return 1;
      3'd2: return 8;
      3'd3: return 64;
      3'd4: return 256;
      3'd5: return 1024;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return {3'b0, m_ctrl};
      3'd1: return m_cnt;
      3'd2: return m_cmp0;
      3'd3: return m_cmp1;
      3'd4: return {5'b0, m_mask};
      3'd5: return {5'b0, m_flags};
      default: return 8'd0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ctrl = '0; m_cnt = '0; m_cmp0 = '0; m_cmp1 = '0;
    m_mask = '0; m_flags = '0; m_out = '0; e = 0;
  endtask

  // one clock edge with the given write; model advanced from the requirements
  task automatic step(input bit w, input logic [2:0] a, input logic [7:0] d);
    logic [2:0] s;
    logic [7:0] inc, n_cnt;
    logic [2:0] set, clr;
    bit tk, ld, ad;
    logic [1:0] tg;
    wr_en = w; addr = a; wdata = d;
    s  = m_ctrl[2:0];
    tk = (s >= 3'd1 && s <= 3'd5) && (((e + 1) % ratio(s)) == 0);
    ld = w && a == 3'd1;
    ad = tk && !ld;
    inc = m_cnt + 8'd1;
    n_cnt = ld ? d : (ad ? inc : m_cnt);
    set = {ad && inc == m_cmp1, ad && inc == m_cmp0, ad && m_cnt == 8'hFF};
    clr = (w && a == 3'd5) ? d[2:0] : 3'b0;
    tg[0] = (w && a == 3'd0 && d[5]) | (set[1] & m_ctrl[3]);
    tg[1] = (w && a == 3'd0 && d[6]) | (set[2] & m_ctrl[4]);
    @(posedge clk);
    e++;
    m_cnt = n_cnt;
    m_flags = (m_flags & ~clr) | set;
    m_out = m_out ^ tg;
    if (w && a == 3'd0) m_ctrl = d[4:0];
    if (w && a == 3'd2) m_cmp0 = d;
    if (w && a == 3'd3) m_cmp1 = d;
    if (w && a == 3'd4) m_mask = d[2:0];
    #1;
    wr_en = 1'b0; addr = 3'd1;
    #0.1;
    if (!ext_skip) chk(rdata == m_cnt, "R2 R3 R4 counter", rdata, m_cnt);
    chk(irq == |(m_flags & m_mask), "R7 irq", irq, |(m_flags & m_mask));
    chk(cmp_out == m_out, "R8 R9 cmp_out", cmp_out, m_out);
  endtask

  task automatic rd_all(input string req);
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a);
      #0.1;
      chk(rdata == exp_rd(3'(a)), req, rdata, exp_rd(3'(a)));
    end
    addr = 3'd1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 3'd1, 8'd0);
  endtask

  initial begin
    void'($urandom(32'h1234_5eed));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #0.1;
    // R1 reset state, R11 map
    rd_all("R1 R11 reset read");
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(cmp_out == 2'b00, "R1 cmp_out", cmp_out, 0);

    // R4 R5 R8 directed at ratio 1
    step(1, 3'd2, 8'd5);
    step(1, 3'd3, 8'd250);
    step(1, 3'd4, 8'd7);
    step(1, 3'd0, 8'b0001_1001);
    idle(300);
    rd_all("R4 R5 flags after wrap");
    chk(m_flags == 3'b111, "R4 R5 expected all flags", m_flags, 7);
    // R6 write-one-to-clear
    step(1, 3'd5, 8'b0000_0000);
    rd_all("R6 zero write keeps");
    step(1, 3'd0, 8'd0);
    step(1, 3'd5, 8'b0000_0010);
    rd_all("R6 clear A only");
    step(1, 3'd5, 8'hFF);
    rd_all("R6 clear all");

    // R2 ratios 8, 64, 256 and 1024 overflow
    step(1, 3'd0, 8'd2); idle(60);
    step(1, 3'd0, 8'd3); idle(400);
    step(1, 3'd0, 8'd4); idle(1100);
    step(1, 3'd1, 8'd254);
    step(1, 3'd0, 8'd5); idle(2100);
    rd_all("R2 R4 slow ratio");

    // R9 force toggles, read back 0
    step(1, 3'd0, 8'b0010_0000);
    step(1, 3'd0, 8'b0100_0000);
    step(1, 3'd0, 8'b0110_1000);
    rd_all("R9 force readback");
    // R11 unused addresses ignore writes
    step(1, 3'd6, 8'hAA);
    step(1, 3'd7, 8'h55);
    rd_all("R11 unused addresses");

    // R10 external edges
    step(1, 3'd2, 8'd200);
    step(1, 3'd3, 8'd201);
    step(1, 3'd1, 8'd10);
    step(1, 3'd0, 8'd7);
    ext_skip = 1'b1;
    for (int p = 0; p < 3; p++) begin
      ext_evt = 1'b1; idle(4);
      ext_evt = 1'b0; idle(4);
    end
    idle(4);
    addr = 3'd1; #0.1;
    chk(rdata == 8'd13, "R10 rising count", rdata, 13);
    step(1, 3'd0, 8'd6);
    ext_evt = 1'b1; idle(5);
    addr = 3'd1; #0.1;
    chk(rdata == 8'd13, "R10 rising ignored in falling mode", rdata, 13);
    ext_evt = 1'b0; idle(5);
    addr = 3'd1; #0.1;
    chk(rdata == 8'd14, "R10 falling count", rdata, 14);
    m_cnt = 8'd14;
    ext_skip = 1'b0;
    step(1, 3'd0, 8'd0);

    // random mix, R3 R6 same-cycle cases included
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(99) < 30) begin
        logic [2:0] ra;
        logic [7:0] rd;
        ra = 3'($urandom_range(7));
        rd = 8'($urandom);
        if (ra == 3'd0) rd[2:0] = 3'($urandom_range(3) == 0 ? $urandom_range(5) : 1);
        step(1, ra, rd);
      end else begin
        step(0, 3'd1, 8'd0);
      end
      if (i % 50 == 49) rd_all("R11 random readback");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule